// File: doc/BRIEF.md
# Firmware Chunk Staging Mailbox

This block is the device side of a small register mailbox through which a host pushes a firmware image into local storage, a piece at a time. The host writes a request object dword by dword into a data register. The object carries a size header, a load command and the chunk itself. The host then sets a start bit, polls for completion and pulls a four-dword reply out of a read register. It acknowledges each reply dword with a write.

Each reply names the byte offset of the image that the device wants next. The host keeps sending whatever offset it is told. The device takes at most one chunk per transaction and can ask for the same offset twice. An offset of all ones tells the host that the whole image is in place. A downstream consumer reads the stored image through a separate read port, and a done flag shows when the image is complete.

Top module: `stg_mbox_responder`

## Requirements
- R1: `reg_addr[3:2]` selects the register: 0 is control (byte 0x0), 1 is status (0x4), 2 is write-data (0x8) and 3 is read-data (0xC). An access with `reg_addr[1:0]` not zero has no effect and reads 0. Reads of control and write-data return 0. After reset, status, read-data and `img_done` are all 0.
- R2: Status bit 31 is ready and bit 2 is error; every other bit reads 0. A control write with bit 31 set and bit 0 clear starts evaluation. In the cycle after that write, status reads 0. From the next cycle on, bit 31 is 1 and bit 2 shows whether the request was rejected.
- R3: A request is accepted only if all of the following hold. Dword 0 equals `{8'h00, 8'h0B, VENDOR_ID}`. Dword 1 equals the number of dwords written since the last evaluation or abort. Dword 2 is 3 and dword 3 is 0. The chunk holds 1 to CHUNK_DWORDS dwords, does not run past the image end, and the image is not yet complete.
- R4: The reply is four dwords, read in this order: `{8'h00, 8'h0B, VENDOR_ID}`, then 4, then the next byte offset, then a status word. The status word is 1 when the image is complete, 2 when the device needs more data, and 4 when the request was rejected.
- R5: A rejected request stores nothing and leaves the requested offset unchanged.
- R6: An accepted chunk is written to the image starting at the current dword offset. The offset then advances by the chunk length, and the reply reports it as a byte offset (dwords times 4).
- R7: When the offset reaches IMG_DWORDS, the reply offset becomes 0xFFFFFFFF and `img_done` goes high. Later requests are rejected and still report 0xFFFFFFFF.
- R8: After each reset or abort, the first otherwise acceptable chunk that starts at dword REPLAY_OFF is discarded. The device asks for the same offset again with status 2.
- R9: Any write to read-data steps to the next reply dword. After the fourth step, reads return 0 and further steps have no effect. A new evaluation restarts the reply at dword 0.
- R10: A control write with bit 0 set clears any partly written request, the offset, the done flag, ready, error, the pending reply and the replay record. It wins over bit 31 in the same write.
- R11: `img_rdata` returns the stored image dword at `img_raddr`, with no clock delay, and returns 0 for addresses at or past IMG_DWORDS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| img_raddr | input | IMG_AW | Image read address in dwords |
| img_rdata | output | 32 | Image read data |
| img_done | output | 1 | Whole image stored |

## Verification
The bench builds the block with a 24-dword image, 8-dword chunks, the replay point at dword 8 and vendor ID 0x5A17. These sizes let a short run reach every case. Three full chunks complete the image. A six-dword chunk followed by a four-dword chunk runs past the end. A nine-dword request overflows the chunk limit. The replay point falls on the second chunk, so the discard-and-reask path runs both before and after an abort.

// File: rtl/stg_pkg.sv
`timescale 1ns/1ps
package stg_pkg;
  localparam logic [7:0]  OBJ_KIND   = 8'h0B;
  localparam logic [31:0] CMD_LOAD   = 32'd3;
  localparam logic [31:0] REPLY_LEN  = 32'd4;
  localparam logic [31:0] OFF_FINISH = 32'hFFFF_FFFF;
  localparam logic [31:0] ST_DONE    = 32'd1;
  localparam logic [31:0] ST_MORE    = 32'd2;
  localparam logic [31:0] ST_FAIL    = 32'd4;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_WDAT = 2'd2,
    SEL_RDAT = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [31:0] size_lo;
    logic [31:0] size_hi;
    logic [31:0] cmd_lo;
    logic [31:0] cmd_hi;
  } req_hdr_t;

  function automatic logic [31:0] size_word_lo(input logic [15:0] vid);
    return {8'h00, OBJ_KIND, vid};
  endfunction

  function automatic logic [31:0] reply_offset(input logic [31:0] off_dw, input logic fin);
    return fin ? OFF_FINISH : (off_dw << 2);
  endfunction

  function automatic logic chunk_fits(input int unsigned words, input int unsigned off_dw,
                                      input int unsigned chunk_max, input int unsigned img_len);
    if (words <= 4) return 1'b0;
    if (words - 4 > chunk_max) return 1'b0;
    if (off_dw > img_len) return 1'b0;
    return (words - 4) <= (img_len - off_dw);
  endfunction
endpackage

// File: rtl/stg_collect.sv
`timescale 1ns/1ps
module stg_collect
  import stg_pkg::*;
#(
  parameter int CHUNK_DWORDS = 8,
  localparam int MAXC = CHUNK_DWORDS + 5,
  localparam int CW = $clog2(MAXC + 1)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               clear,
  input  logic                               wr,
  input  logic                               eval,
  input  logic [31:0]                        wdata,
  output req_hdr_t                           hdr,
  output logic [CW-1:0]                      cnt,
  output logic [CHUNK_DWORDS-1:0][31:0]      chunk_buf
);
  logic take;
  assign take = wr && !clear && !eval;

  always_ff @(posedge clk) begin
    if (!rst_n || clear || eval) begin
      cnt <= '0;
      hdr <= '0;
    end else if (take) begin
      if (cnt < CW'(MAXC)) cnt <= cnt + CW'(1);
      case (cnt)
        CW'(0): hdr.size_lo <= wdata;
        CW'(1): hdr.size_hi <= wdata;
        CW'(2): hdr.cmd_lo  <= wdata;
        CW'(3): hdr.cmd_hi  <= wdata;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < CHUNK_DWORDS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) chunk_buf[g] <= '0;
      else if (take && cnt == CW'(g + 4)) chunk_buf[g] <= wdata;
    end
  end

  p_count_saturates_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cnt == CW'(MAXC)) |=> cnt == CW'(MAXC));
  p_eval_restarts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eval |=> cnt == '0);
endmodule

// File: rtl/stg_judge.sv
`timescale 1ns/1ps
module stg_judge
  import stg_pkg::*;
#(
  parameter int IMG_DWORDS = 24,
  parameter int CHUNK_DWORDS = 8,
  parameter int REPLAY_OFF = 8,
  parameter logic [15:0] VENDOR_ID = 16'h5A17,
  localparam int CW = $clog2(CHUNK_DWORDS + 6),
  localparam int OW = $clog2(IMG_DWORDS + 1),
  localparam int CIW = (CHUNK_DWORDS > 1) ? $clog2(CHUNK_DWORDS) : 1,
  localparam int IMG_AW = (IMG_DWORDS > 1) ? $clog2(IMG_DWORDS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clear,
  input  logic                          eval,
  input  req_hdr_t                      hdr,
  input  logic [CW-1:0]                 cnt,
  input  logic [CHUNK_DWORDS-1:0][31:0] chunk_buf,
  output logic                          verdict_ok,
  output logic [31:0]                   nxt_off_word,
  output logic [31:0]                   nxt_stat_word,
  output logic                          img_done,
  input  logic [IMG_AW-1:0]             img_raddr,
  output logic [31:0]                   img_rdata
);
  logic [OW-1:0] off;
  logic [OW-1:0] off_next;
  logic          done, replayed, done_next;
  logic [CW-1:0] n_data;
  logic          hdr_ok, fits, valid, replay, commit;
  logic [31:0]   img_mem [IMG_DWORDS];

  assign n_data = cnt - CW'(4);
  assign hdr_ok = (hdr.size_lo == size_word_lo(VENDOR_ID)) && (hdr.size_hi == 32'(cnt))
               && (hdr.cmd_lo == CMD_LOAD) && (hdr.cmd_hi == 32'd0);
  assign fits   = chunk_fits(32'(cnt), 32'(off), CHUNK_DWORDS, IMG_DWORDS);
  assign valid  = hdr_ok && fits && !done;
  assign replay = valid && (32'(off) == REPLAY_OFF) && !replayed;
  assign commit = valid && !replay;

  assign off_next  = commit ? off + OW'(n_data) : off;
  assign done_next = (32'(off_next) == IMG_DWORDS);

  assign verdict_ok    = valid;
  assign nxt_off_word  = reply_offset(32'(off_next), done_next);
  assign nxt_stat_word = !valid ? ST_FAIL : (done_next ? ST_DONE : ST_MORE);
  assign img_done      = done;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      off      <= '0;
      done     <= 1'b0;
      replayed <= 1'b0;
    end else if (eval) begin
      off  <= off_next;
      done <= done_next;
      if (replay) replayed <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int w = 0; w < IMG_DWORDS; w++) begin
      if (eval && commit && w >= int'(off) && w < int'(off) + int'(n_data))
        img_mem[w] <= chunk_buf[CIW'(w - int'(off))];
    end
  end

  assign img_rdata = (32'(img_raddr) < IMG_DWORDS) ? img_mem[img_raddr] : 32'd0;

  p_offset_in_image_r6: assert property (@(posedge clk) disable iff (!rst_n)
    32'(off) <= IMG_DWORDS);
  p_reject_keeps_offset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && !valid && !clear) |=> off == $past(off));
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clear) |=> done);
  p_replay_holds_offset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && replay && !clear) |=> (replayed && off == $past(off)));
endmodule

// File: rtl/stg_reply.sv
`timescale 1ns/1ps
module stg_reply
  import stg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'h5A17
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        load,
  input  logic        ack,
  input  logic [31:0] off_word,
  input  logic [31:0] stat_word,
  output logic [31:0] rd_word
);
  logic [2:0]  ptr;
  logic [31:0] off_q, stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr    <= 3'd4;
      off_q  <= '0;
      stat_q <= '0;
    end else if (clear) begin
      ptr <= 3'd4;
    end else if (load) begin
      ptr    <= 3'd0;
      off_q  <= off_word;
      stat_q <= stat_word;
    end else if (ack && ptr < 3'd4) begin
      ptr <= ptr + 3'd1;
    end
  end

  always_comb begin
    case (ptr)
      3'd0:    rd_word = size_word_lo(VENDOR_ID);
      3'd1:    rd_word = REPLY_LEN;
      3'd2:    rd_word = off_q;
      3'd3:    rd_word = stat_q;
      default: rd_word = 32'd0;
    endcase
  end

  p_ack_steps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !load && !clear && ptr < 3'd4) |=> ptr == $past(ptr) + 3'd1);
  p_drained_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr == 3'd4) |-> rd_word == 32'd0);
endmodule

// File: rtl/stg_mbox_responder.sv
`timescale 1ns/1ps
module stg_mbox_responder
  import stg_pkg::*;
#(
  parameter int IMG_DWORDS = 24,
  parameter int CHUNK_DWORDS = 8,
  parameter int REPLAY_OFF = 8,
  parameter logic [15:0] VENDOR_ID = 16'h5A17,
  localparam int IMG_AW = (IMG_DWORDS > 1) ? $clog2(IMG_DWORDS) : 1,
  localparam int CW = $clog2(CHUNK_DWORDS + 6)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [IMG_AW-1:0] img_raddr,
  output logic [31:0]       img_rdata,
  output logic              img_done
);
  reg_sel_e sel;
  logic     aligned, wr_ctrl, abort_evt, go_evt, wr_word, ack_evt, eval_evt;
  logic     busy, ready, err_q;
  logic     verdict_ok;
  logic [31:0] nxt_off_word, nxt_stat_word, reply_word;
  req_hdr_t hdr;
  logic [CW-1:0] cnt;
  logic [CHUNK_DWORDS-1:0][31:0] chunk_buf;

  assign sel       = reg_sel_e'(reg_addr[3:2]);
  assign aligned   = (reg_addr[1:0] == 2'b00);
  assign wr_ctrl   = reg_wr && aligned && sel == SEL_CTRL;
  assign abort_evt = wr_ctrl && reg_wdata[0];
  assign go_evt    = wr_ctrl && reg_wdata[31] && !reg_wdata[0] && !busy;
  assign wr_word   = reg_wr && aligned && sel == SEL_WDAT && !busy;
  assign ack_evt   = reg_wr && aligned && sel == SEL_RDAT;
  assign eval_evt  = busy && !abort_evt;

  always_ff @(posedge clk) begin
    if (!rst_n || abort_evt) begin
      busy  <= 1'b0;
      ready <= 1'b0;
      err_q <= 1'b0;
    end else if (go_evt) begin
      busy  <= 1'b1;
      ready <= 1'b0;
      err_q <= 1'b0;
    end else if (busy) begin
      busy  <= 1'b0;
      ready <= 1'b1;
      err_q <= !verdict_ok;
    end
  end

  stg_collect #(.CHUNK_DWORDS(CHUNK_DWORDS)) u_collect (
    .clk(clk), .rst_n(rst_n), .clear(abort_evt), .wr(wr_word), .eval(eval_evt),
    .wdata(reg_wdata), .hdr(hdr), .cnt(cnt), .chunk_buf(chunk_buf)
  );

  stg_judge #(
    .IMG_DWORDS(IMG_DWORDS), .CHUNK_DWORDS(CHUNK_DWORDS),
    .REPLAY_OFF(REPLAY_OFF), .VENDOR_ID(VENDOR_ID)
  ) u_judge (
    .clk(clk), .rst_n(rst_n), .clear(abort_evt), .eval(eval_evt), .hdr(hdr),
    .cnt(cnt), .chunk_buf(chunk_buf), .verdict_ok(verdict_ok),
    .nxt_off_word(nxt_off_word), .nxt_stat_word(nxt_stat_word),
    .img_done(img_done), .img_raddr(img_raddr), .img_rdata(img_rdata)
  );

  stg_reply #(.VENDOR_ID(VENDOR_ID)) u_reply (
    .clk(clk), .rst_n(rst_n), .clear(abort_evt), .load(eval_evt), .ack(ack_evt),
    .off_word(nxt_off_word), .stat_word(nxt_stat_word), .rd_word(reply_word)
  );

  always_comb begin
    reg_rdata = 32'd0;
    if (aligned) begin
      case (sel)
        SEL_STAT: reg_rdata = {ready, 28'd0, err_q, 2'b00};
        SEL_RDAT: reg_rdata = reply_word;
        default:  reg_rdata = 32'd0;
      endcase
    end
  end

  p_ready_follows_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(busy));
  p_go_drops_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    go_evt |=> !ready);
  p_abort_quiets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (!ready && !busy && !img_done));
endmodule

// File: tb/sim_stg_mbox_responder.sv
`timescale 1ns/1ps
module sim_stg_mbox_responder;
  localparam int IMG = 24;
  localparam int CHK = 8;
  localparam int REP = 8;
  localparam logic [15:0] VID = 16'h5A17;
  localparam int AW = $clog2(IMG);
  localparam logic [3:0] A_CT = 4'h0, A_ST = 4'h4, A_WD = 4'h8, A_RD = 4'hC;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, img_rdata;
  logic [AW-1:0] img_raddr = '0;
  logic img_done;

  stg_mbox_responder #(.IMG_DWORDS(IMG), .CHUNK_DWORDS(CHK), .REPLAY_OFF(REP), .VENDOR_ID(VID)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .img_raddr(img_raddr), .img_rdata(img_rdata), .img_done(img_done)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int m_off = 0;
  bit m_done = 0, m_rep = 0, finished = 0;
  logic [31:0] m_img [IMG];
  bit m_known [IMG];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // per-clock comparison of the done flag against the model (R7)
  always @(posedge clk) begin
    #3;
    check("R7 done flag per cycle", {31'd0, img_done}, {31'd0, m_done});
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #2 d = reg_rdata;
    @(negedge clk);
  endtask

  task automatic send(input string tag, input logic [15:0] vid, input logic [7:0] typ,
                      input int len_adj, input logic [31:0] cmd, input int n, input logic [31:0] seed);
    logic [31:0] v, e_off, e_st;
    bit ok, rep;
    wr(A_WD, {8'h00, typ, vid});
    wr(A_WD, 32'(n + 4 + len_adj));
    wr(A_WD, cmd);
    wr(A_WD, 32'd0);
    for (int i = 0; i < n; i++) wr(A_WD, seed + 32'(i));
    wr(A_CT, 32'h8000_0000);
    ok  = (vid == VID) && (typ == 8'h0B) && (len_adj == 0) && (cmd == 32'd3)
          && (n >= 1) && (n <= CHK) && (n <= IMG - m_off) && !m_done;
    rep = ok && (m_off == REP) && !m_rep;
    if (rep) m_rep = 1;
    if (ok && !rep) begin
      for (int i = 0; i < n; i++) begin
        m_img[m_off + i] = seed + 32'(i);
        m_known[m_off + i] = 1;
      end
      m_off += n;
      if (m_off == IMG) m_done = 1;
    end
    e_off = m_done ? 32'hFFFF_FFFF : 32'(m_off * 4);
    e_st  = !ok ? 32'd4 : (m_done ? 32'd1 : 32'd2);
    rd(A_ST, v); check({tag, " R2 status while busy"}, v, 32'd0);
    rd(A_ST, v); check({tag, " R2 R3 status after verdict"}, v, ok ? 32'h8000_0000 : 32'h8000_0004);
    rd(A_RD, v); check({tag, " R4 reply header low"}, v, {8'h00, 8'h0B, VID});
    wr(A_RD, 32'd0);
    rd(A_RD, v); check({tag, " R4 reply header high"}, v, 32'd4);
    wr(A_RD, 32'd0);
    rd(A_RD, v); check({tag, " R4 R6 R8 reply offset"}, v, e_off);
    wr(A_RD, 32'd0);
    rd(A_RD, v); check({tag, " R4 reply status"}, v, e_st);
    wr(A_RD, 32'd0);
    rd(A_RD, v); check({tag, " R9 drained reply"}, v, 32'd0);
  endtask

  task automatic readback(input string tag);
    for (int w = 0; w < IMG; w++) begin
      if (m_known[w]) begin
        img_raddr = AW'(w);
        #1 check({tag, " R5 R6 R11 image word"}, img_rdata, m_img[w]);
        @(negedge clk);
      end
    end
  endtask

  task automatic abort_with(input logic [31:0] d);
    m_off = 0; m_done = 0; m_rep = 0;
    wr(A_CT, d);
  endtask

  initial begin
    logic [31:0] v;
    for (int w = 0; w < IMG; w++) m_known[w] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state and decode
    rd(A_ST, v); check("R1 status after reset", v, 32'd0);
    rd(A_RD, v); check("R1 read-data after reset", v, 32'd0);
    rd(A_CT, v); check("R1 control reads zero", v, 32'd0);
    rd(A_WD, v); check("R1 write-data reads zero", v, 32'd0);
    // R3 / R5 rejections
    send("bad vendor",  16'h1111, 8'h0B, 0, 32'd3, 4, 32'hBAD0_0000);
    send("bad kind",    VID,      8'h0C, 0, 32'd3, 4, 32'hBAD1_0000);
    send("bad command", VID,      8'h0B, 0, 32'd5, 4, 32'hBAD2_0000);
    send("bad length",  VID,      8'h0B, 1, 32'd3, 4, 32'hBAD3_0000);
    // R6 / R8 normal flow with replay
    send("first chunk",    VID, 8'h0B, 0, 32'd3, 8, 32'h1000_0000);
    send("replayed chunk", VID, 8'h0B, 0, 32'd3, 8, 32'hDEAD_0000);
    send("resent chunk",   VID, 8'h0B, 0, 32'd3, 8, 32'h2000_0000);
    send("oversize chunk", VID, 8'h0B, 0, 32'd3, 9, 32'hBEEF_0000);
    send("six dwords",     VID, 8'h0B, 0, 32'd3, 6, 32'h3000_0000);
    send("past image end", VID, 8'h0B, 0, 32'd3, 4, 32'hBAD4_0000);
    // R7 completion
    send("final chunk",    VID, 8'h0B, 0, 32'd3, 2, 32'h4000_0000);
    send("after done",     VID, 8'h0B, 0, 32'd3, 2, 32'hBAD5_0000);
    readback("full image");
    img_raddr = AW'(IMG);
    #1 check("R11 address past image", img_rdata, 32'd0);
    @(negedge clk);
    // R9 extra acks after draining
    wr(A_RD, 32'd0);
    rd(A_RD, v); check("R9 extra ack ignored", v, 32'd0);
    // R1 misaligned access
    reg_wr = 1'b1; reg_addr = 4'h1; reg_wdata = 32'h8000_0001;
    @(negedge clk); reg_wr = 1'b0;
    rd(4'h5, v); check("R1 misaligned read", v, 32'd0);
    rd(A_ST, v); check("R1 misaligned write no effect", v, 32'h8000_0004);
    // R10 abort clears partial request and state
    wr(A_WD, {8'h00, 8'h0B, VID});
    wr(A_WD, 32'd12);
    abort_with(32'h0000_0001);
    rd(A_ST, v); check("R10 status after abort", v, 32'd0);
    rd(A_RD, v); check("R10 reply cleared by abort", v, 32'd0);
    send("post-abort first", VID, 8'h0B, 0, 32'd3, 8, 32'h6000_0000);
    send("post-abort replay", VID, 8'h0B, 0, 32'd3, 8, 32'hDEAD_1000);
    send("post-abort resend", VID, 8'h0B, 0, 32'd3, 8, 32'h7000_0000);
    abort_with(32'h8000_0001);
    rd(A_ST, v); check("R10 abort wins over go", v, 32'd0);
    rd(A_ST, v); check("R10 no verdict after abort with go", v, 32'd0);
    readback("image kept");
    wrap_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    wrap_up();
  end
endmodule